// File: doc/BRIEF.md
# Watchdog Counter with Sticky Mode and Unlock Sequence

This block is a register-mapped down-counter. It runs in one of two ways. In timer mode it counts down from a programmed start value. When it reaches zero it can raise an interrupt, and it can optionally restart from the stored start value. In watchdog mode, reaching zero sets a sticky reset flag and drives a reset-request output. No interrupt is raised and the counter does not restart. The request is meant for a separate reset controller.

Once watchdog mode is set, software cannot leave it by writing the control register. The only way out is to write two specific words back to back into a write-only disable register. While watchdog mode is set, software also cannot move the counter by writing it directly. The counter steps once every 16^p clock cycles, where p is a three-bit exponent in the control register.

Top module: `wdog_unit`

## Requirements
- R1: After reset, every readable register reads 0, and `irq` and `rst_req` are low.
- R2: A write to the start-value register (offset 0x20) stores the value, which reads back. If the enable bit is set, the write also restarts the count (offset 0x24) at that value. If the enable bit is clear, the count is unchanged.
- R3: A write to the count register, with enable set and watchdog mode clear, sets the count to the written value. With watchdog mode set, the write has no effect.
- R4: A control write (offset 0x28) that turns the enable bit (bit 0) from 0 to 1 restarts the count from the stored start value.
- R5: The watchdog-mode bit (control bit 3) reads back as written when it is set. A later control write with bit 3 clear leaves it set.
- R6: Watchdog mode clears only when two consecutive writes to the disable register (offset 0x34) carry 0x12345678 and then 0x87654321. Any other word in between breaks the sequence. Every written word becomes the new previous word.
- R7: In timer mode with interrupt enable (bit 2) set, a start value V at prescale 0 expires V cycles after the restart. Expiry sets the raw flag (bit 0 at 0x2C) and raises `irq`.
- R8: In timer mode with auto-restart (bit 1) set, expiry reloads the count from the stored start value. Without auto-restart, the count stays at 0 and the counter stops.
- R9: In watchdog mode, expiry sets the raw flag and the reset flag (bit 0 at 0x30) and drives `rst_req` high. `irq` does not rise and the counter does not reload.
- R10: Any write to 0x2C clears the raw flag and `irq`. Any write to 0x30 clears the reset flag and `rst_req`.
- R11: With exponent p in control bits [10:8], the count decrements once every 16^p cycles. At p=1, a start value of 2 expires 32 cycles after the restart.
- R12: The disable register and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Timer-mode interrupt, held until cleared |
| rst_req | output | 1 | Reset request, follows the reset flag |

## Verification
Suppose the internal mode bit wrongly clears. Then the next count write changes the count readback at the following read, and the next expiry shows up on `irq` instead of `rst_req`. A wrong prescaler or counter state shifts the edge of `irq` or `rst_req` by at least one cycle. For that reason the expiry checks sample the cycle just before the expected edge and the cycle of the edge itself. A broken unlock tracker shows in the control readback one cycle after the second disable write.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 8;
  localparam int PRE_EXP_W = 3;
  localparam int PRE_LSB   = 8;
  // width able to hold 16^(2^PRE_EXP_W - 1) - 1
  localparam int PRE_DIV_W = 4 * ((1 << PRE_EXP_W) - 1);

  localparam logic [ADDR_W-1:0] OFS_START = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_COUNT = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_IFLAG = 8'h2C;
  localparam logic [ADDR_W-1:0] OFS_RFLAG = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_KEY   = 8'h34;

  localparam logic [DATA_W-1:0] KEY_FIRST  = 32'h1234_5678;
  localparam logic [DATA_W-1:0] KEY_SECOND = 32'h8765_4321;

  typedef struct packed {
    logic [PRE_EXP_W-1:0] pre_exp;
    logic                 wd_mode;
    logic                 irq_en;
    logic                 auto_rl;
    logic                 run;
  } wd_ctl_t;

  function automatic wd_ctl_t ctl_from_word(input logic [DATA_W-1:0] d);
    wd_ctl_t c;
    c.run     = d[0];
    c.auto_rl = d[1];
    c.irq_en  = d[2];
    c.wd_mode = d[3];
    c.pre_exp = d[PRE_LSB +: PRE_EXP_W];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] ctl_to_word(input wd_ctl_t c);
    logic [DATA_W-1:0] d;
    d = '0;
    d[0] = c.run;
    d[1] = c.auto_rl;
    d[2] = c.irq_en;
    d[3] = c.wd_mode;
    d[PRE_LSB +: PRE_EXP_W] = c.pre_exp;
    return d;
  endfunction

  // cycles per decrement minus one: 16^e - 1
  function automatic logic [PRE_DIV_W-1:0] pre_limit(input logic [PRE_EXP_W-1:0] e);
    logic [PRE_DIV_W-1:0] one;
    one = {{(PRE_DIV_W-1){1'b0}}, 1'b1};
    return (one << (4 * e)) - one;
  endfunction
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler
  import wdog_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 clr,
  input  logic [PRE_EXP_W-1:0] exp_sel,
  output logic                 tick
);
  logic [PRE_DIV_W-1:0] pre_cnt_q;

  assign tick = en && (pre_cnt_q == pre_limit(exp_sel));

  always_ff @(posedge clk) begin
    if (!rst_n || clr || tick) pre_cnt_q <= '0;
    else if (en)               pre_cnt_q <= pre_cnt_q + 1'b1;
  end

  AST_TICK_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> pre_cnt_q == '0); // R11
  AST_PRE_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && !tick) |=> pre_cnt_q == $past(pre_cnt_q) + 1'b1); // R11
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              run,
  input  logic              auto_rl,
  input  logic              wd_mode,
  input  logic              restart,
  input  logic [DATA_W-1:0] restart_val,
  input  logic [DATA_W-1:0] start_val,
  output logic              expire,
  output logic              reload,
  output logic [DATA_W-1:0] count
);
  logic [DATA_W-1:0] count_q;
  logic              armed_q;

  assign expire = armed_q && run && tick && (count_q <= DATA_W'(1));
  assign reload = expire && auto_rl && !wd_mode;
  assign count  = count_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      armed_q <= 1'b0;
    end else if (restart) begin
      count_q <= restart_val;
      armed_q <= 1'b1;
    end else if (expire) begin
      if (reload) begin
        count_q <= start_val;
      end else begin
        count_q <= '0;
        armed_q <= 1'b0;
      end
    end else if (armed_q && run && tick) begin
      count_q <= count_q - 1'b1;
    end
  end

  AST_STOP_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !reload && !restart) |=> count_q == '0); // R8
endmodule

// File: rtl/wdog_unit.sv
module wdog_unit
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              rst_req
);
  wd_ctl_t           ctl_q, ctl_wr;
  logic [DATA_W-1:0] start_q, prev_key_q, restart_val, count;
  logic              raw_q, pend_q, rflag_q;
  logic              wr_start, wr_count, wr_ctrl, wr_iflag, wr_rflag, wr_key;
  logic              run_rise, restart, unlock_hit, tick, expire, reload, wd_mode;

  assign wr_start = wr_en && addr == OFS_START;
  assign wr_count = wr_en && addr == OFS_COUNT;
  assign wr_ctrl  = wr_en && addr == OFS_CTRL;
  assign wr_iflag = wr_en && addr == OFS_IFLAG;
  assign wr_rflag = wr_en && addr == OFS_RFLAG;
  assign wr_key   = wr_en && addr == OFS_KEY;
  assign wd_mode  = ctl_q.wd_mode;

  // control write with the mode bit held once it is set
  always_comb begin
    ctl_wr = ctl_from_word(wdata);
    ctl_wr.wd_mode = ctl_wr.wd_mode | ctl_q.wd_mode;
  end

  assign run_rise   = wr_ctrl && !ctl_q.run && ctl_wr.run;
  assign unlock_hit = wr_key && prev_key_q == KEY_FIRST && wdata == KEY_SECOND;

  always_comb begin
    restart     = 1'b0;
    restart_val = start_q;
    if (wr_start && ctl_q.run) begin
      restart     = 1'b1;
      restart_val = wdata;
    end else if (wr_count && ctl_q.run && !ctl_q.wd_mode) begin
      restart     = 1'b1;
      restart_val = wdata;
    end else if (run_rise) begin
      restart     = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q      <= '0;
      start_q    <= '0;
      prev_key_q <= '0;
    end else begin
      if (wr_start) start_q <= wdata;
      if (wr_key)   prev_key_q <= wdata;
      if (wr_ctrl)         ctl_q <= ctl_wr;
      else if (unlock_hit) ctl_q.wd_mode <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q   <= 1'b0;
      pend_q  <= 1'b0;
      rflag_q <= 1'b0;
    end else begin
      if (expire) begin
        raw_q <= 1'b1;
        if (ctl_q.wd_mode)     rflag_q <= 1'b1;
        else if (ctl_q.irq_en) pend_q  <= 1'b1;
      end else if (wr_iflag) begin
        raw_q  <= 1'b0;
        pend_q <= 1'b0;
      end
      if (wr_rflag && !(expire && ctl_q.wd_mode)) rflag_q <= 1'b0;
    end
  end

  wdog_prescaler u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (ctl_q.run),
    .clr     (restart || expire),
    .exp_sel (ctl_q.pre_exp),
    .tick    (tick)
  );

  wdog_counter u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .run         (ctl_q.run),
    .auto_rl     (ctl_q.auto_rl),
    .wd_mode     (ctl_q.wd_mode),
    .restart     (restart),
    .restart_val (restart_val),
    .start_val   (start_q),
    .expire      (expire),
    .reload      (reload),
    .count       (count)
  );

  always_comb begin
    case (addr)
      OFS_START: rdata = start_q;
      OFS_COUNT: rdata = count;
      OFS_CTRL:  rdata = ctl_to_word(ctl_q);
      OFS_IFLAG: rdata = {{(DATA_W-1){1'b0}}, raw_q};
      OFS_RFLAG: rdata = {{(DATA_W-1){1'b0}}, rflag_q};
      default:   rdata = '0;
    endcase
  end

  assign irq     = pend_q;
  assign rst_req = rflag_q;

  AST_MODE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wd_mode) |-> $past(unlock_hit)); // R5
  AST_COUNT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_mode && wr_count) |=> count <= $past(count)); // R3
  AST_WD_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && wd_mode) |=> rflag_q && irq == $past(irq)); // R9
  AST_IRQ_HAS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> raw_q); // R7
  AST_RISE_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    run_rise |=> count == $past(start_q)); // R4
  AST_NO_RELOAD_WD: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && wd_mode) |-> !reload); // R9
endmodule

// File: tb/wdog_unit_tb.sv
module wdog_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, rst_req;
  int          n_run = 0;
  int          n_fail = 0;
  logic [31:0] v;

  always #5 clk = ~clk;

  wdog_unit dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .rst_req(rst_req)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  a;
    logic [31:0] d;
    logic [31:0] e;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h20, 32'h0,        32'h0,   8'd1},  // R1
    '{1'b0, 8'h28, 32'h0,        32'h0,   8'd1},  // R1
    '{1'b0, 8'h2C, 32'h0,        32'h0,   8'd1},  // R1
    '{1'b0, 8'h30, 32'h0,        32'h0,   8'd1},  // R1
    '{1'b1, 8'h20, 32'h100,      32'h0,   8'd2},  // R2 store while idle
    '{1'b0, 8'h20, 32'h0,        32'h100, 8'd2},
    '{1'b0, 8'h24, 32'h0,        32'h0,   8'd2},  // R2 no restart when disabled
    '{1'b1, 8'h28, 32'h8,        32'h0,   8'd5},  // R5
    '{1'b0, 8'h28, 32'h0,        32'h8,   8'd5},
    '{1'b1, 8'h28, 32'h0,        32'h0,   8'd5},
    '{1'b0, 8'h28, 32'h0,        32'h8,   8'd5},  // R5 mode held
    '{1'b1, 8'h34, 32'h12345678, 32'h0,   8'd6},  // R6 broken sequence
    '{1'b1, 8'h34, 32'h11111111, 32'h0,   8'd6},
    '{1'b1, 8'h34, 32'h87654321, 32'h0,   8'd6},
    '{1'b0, 8'h28, 32'h0,        32'h8,   8'd6},
    '{1'b1, 8'h34, 32'h12345678, 32'h0,   8'd6},  // R6 proper sequence
    '{1'b1, 8'h34, 32'h87654321, 32'h0,   8'd6},
    '{1'b0, 8'h28, 32'h0,        32'h0,   8'd6},
    '{1'b0, 8'h34, 32'h0,        32'h0,   8'd12}, // R12
    '{1'b0, 8'h00, 32'h0,        32'h0,   8'd12},
    '{1'b1, 8'h28, 32'h705,      32'h0,   8'd4},  // R4 enable rise
    '{1'b0, 8'h24, 32'h0,        32'h100, 8'd4},
    '{1'b1, 8'h24, 32'h42,       32'h0,   8'd3},  // R3 timer mode write
    '{1'b0, 8'h24, 32'h0,        32'h42,  8'd3},
    '{1'b1, 8'h28, 32'h70D,      32'h0,   8'd3},
    '{1'b1, 8'h24, 32'h99,       32'h0,   8'd3},  // R3 ignored in watchdog mode
    '{1'b0, 8'h24, 32'h0,        32'h42,  8'd3},
    '{1'b1, 8'h20, 32'h33,       32'h0,   8'd2},  // R2 restart while enabled
    '{1'b0, 8'h24, 32'h0,        32'h33,  8'd2},
    '{1'b1, 8'h34, 32'h12345678, 32'h0,   8'd6},
    '{1'b1, 8'h34, 32'h87654321, 32'h0,   8'd6},
    '{1'b0, 8'h28, 32'h0,        32'h705, 8'd6},
    '{1'b1, 8'h28, 32'h0,        32'h0,   8'd4},
    '{1'b0, 8'h28, 32'h0,        32'h0,   8'd4}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 rst_req", {31'b0, rst_req}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) wr_reg(VECS[i].a, VECS[i].d);
      else begin
        rd_reg(VECS[i].a, v);
        check($sformatf("R%0d vec%0d", VECS[i].req, i), v, VECS[i].e);
      end
    end

    // R7 / R8: timer expiry, no auto-restart
    wr_reg(8'h20, 32'd5);
    wr_reg(8'h28, 32'h5);
    repeat (4) @(negedge clk);
    check("R7 irq before expiry", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R7 irq at expiry", {31'b0, irq}, 32'h1);
    rd_reg(8'h2C, v); check("R7 raw flag", v, 32'h1);
    repeat (10) @(negedge clk);
    rd_reg(8'h24, v); check("R8 stopped at zero", v, 32'h0);
    wr_reg(8'h2C, 32'h0);
    rd_reg(8'h2C, v); check("R10 raw cleared", v, 32'h0);
    check("R10 irq cleared", {31'b0, irq}, 32'h0);

    // R11 / R8: prescale 16, auto-restart
    wr_reg(8'h28, 32'h0);
    wr_reg(8'h20, 32'd2);
    wr_reg(8'h28, 32'h107);
    repeat (31) @(negedge clk);
    check("R11 irq before 32 cycles", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R11 irq at 32 cycles", {31'b0, irq}, 32'h1);
    rd_reg(8'h24, v); check("R8 reloaded", v, 32'h2);
    wr_reg(8'h2C, 32'h0);
    wr_reg(8'h28, 32'h0);

    // R9: watchdog expiry
    wr_reg(8'h20, 32'd3);
    wr_reg(8'h28, 32'hF);
    repeat (2) @(negedge clk);
    check("R9 rst_req before expiry", {31'b0, rst_req}, 32'h0);
    @(negedge clk);
    check("R9 rst_req at expiry", {31'b0, rst_req}, 32'h1);
    check("R9 no irq", {31'b0, irq}, 32'h0);
    rd_reg(8'h30, v); check("R9 reset flag", v, 32'h1);
    rd_reg(8'h2C, v); check("R9 raw flag", v, 32'h1);
    repeat (5) @(negedge clk);
    rd_reg(8'h24, v); check("R9 no reload", v, 32'h0);
    check("R9 irq stays low", {31'b0, irq}, 32'h0);
    wr_reg(8'h30, 32'h0);
    check("R10 rst_req cleared", {31'b0, rst_req}, 32'h0);
    rd_reg(8'h30, v); check("R10 reset flag cleared", v, 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog timeout got=running exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule